// File: doc/BRIEF.md
# Interrupt and Keyed Soft-Reset Register Bank

This block holds the interrupt bookkeeping and the soft-reset trigger of a two-wire bus sequencer. Eight single-cycle event pulses from the sequencer are caught in a sticky status register. An enable register selects which of them may raise the interrupt line. One global gate bit can silence the whole line. Software flips status bits by writing ones to them, which is how it acknowledges serviced events.

A separate write-only location starts a soft reset. The reset fires only when software writes the exact key word 0x0000000A. A valid key write produces a one-cycle pulse to the rest of the peripheral and also returns the interrupt state of this block to zero. Register access is a plain 32-bit port with byte offsets. A read request returns its data one cycle later.

Top module: `irq_rst_regbank`

## Requirements
- R1: The status register sits at offset 0x20, with bit k latching `evt_i[k]`. The bit order is fixed: 0 arbitration lost, 1 transmit error, 2 TX FIFO empty, 3 RX FIFO at threshold, 4 bus not busy, 5 addressed as slave, 6 not addressed as slave, 7 TX FIFO half empty. A set bit stays set until software changes it.
- R2: A write to offset 0x20 inverts every status bit whose `bus_wdata` bit is 1 and leaves the bits written with 0 unchanged.
- R3: When an event fires in the same cycle as a write of 1 to its status bit, the bit is 1 after that edge.
- R4: The enable register sits at offset 0x28 (bits 7:0). After each edge, `irq_o` equals the global gate AND the OR of (status AND enable), as computed from the register values just written at that edge.
- R5: The global gate is bit 31 of offset 0x1C and is the only bit there. A write loads it from `bus_wdata[31]`, and a read returns it in bit 31 with all other bits 0. While the gate is 0, `irq_o` is 0.
- R6: A write of exactly 0x0000000A to offset 0x40 drives `soft_rst_o` high for the one cycle after that edge. At the same edge it clears status, enable and the gate, and events arriving in that cycle are dropped.
- R7: Any other value written to offset 0x40 has no effect: `soft_rst_o` stays 0 and all registers keep their values.
- R8: When `bus_rd` is 1, `bus_rdata` carries the register value from before the edge, in the cycle after the request. Offset 0x40 and every unmapped offset read as 0. When `bus_rd` is 0, `bus_rdata` is 0 in the next cycle.
- R9: The synchronous reset `rst` clears all registers. `irq_o`, `soft_rst_o` and `bus_rdata` are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| evt_i | input | 8 | Event pulses from the sequencer |
| irq_o | output | 1 | Interrupt request, registered |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
The acknowledge path is swept with all 256 write masks against a fixed status pattern. This separates invert-on-one from plain clear or plain load. The interrupt gate is swept across all enable values with several status patterns and both gate settings, which exposes a missing mask bit or a gate ignored on one side. Key writes are checked with a range of near-miss values, including the key with a high bit set. Event/write collisions and reads of every word offset up to 0x44 cover the priority and decode corners.

// File: rtl/irq_rb_pkg.sv
package irq_rb_pkg;
  parameter int unsigned ADDR_W  = 8;
  parameter int unsigned DATA_W  = 32;
  parameter int unsigned EVT_N   = 8;
  parameter logic [7:0]  OFS_GATE = 8'h1C;
  parameter logic [7:0]  OFS_STS  = 8'h20;
  parameter logic [7:0]  OFS_EN   = 8'h28;
  parameter logic [7:0]  OFS_RST  = 8'h40;
  parameter int unsigned RST_KEY  = 32'h0000_000A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GATE,
    SEL_STS,
    SEL_EN,
    SEL_RST
  } reg_sel_e;
endpackage

// File: rtl/irq_rb_decode.sv
module irq_rb_decode
  import irq_rb_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    if (addr == AW'(OFS_GATE))     sel = SEL_GATE;
    else if (addr == AW'(OFS_STS)) sel = SEL_STS;
    else if (addr == AW'(OFS_EN))  sel = SEL_EN;
    else if (addr == AW'(OFS_RST)) sel = SEL_RST;
    else                           sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_rb_status.sv
module irq_rb_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         sts_wr,
  input  logic         en_wr,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] evt,
  output logic [N-1:0] sts_q,
  output logic [N-1:0] en_q,
  output logic [N-1:0] sts_d,
  output logic [N-1:0] en_d
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (clr) begin
        sts_d[i] = 1'b0;
        en_d[i]  = 1'b0;
      end else begin
        // invert on written one, event has priority
        sts_d[i] = (sts_q[i] ^ (sts_wr & wbits[i])) | evt[i];
        en_d[i]  = en_wr ? wbits[i] : en_q[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sts_q[i] <= 1'b0;
        en_q[i]  <= 1'b0;
      end else begin
        sts_q[i] <= sts_d[i];
        en_q[i]  <= en_d[i];
      end
    end
  end
endmodule

// File: rtl/irq_rb_softrst.sv
module irq_rb_softrst #(
  parameter int unsigned DW  = 32,
  parameter int unsigned KEY = 32'hA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [DW-1:0] wdata,
  output logic          fire,
  output logic          pulse_q
);
  assign fire = hit && (wdata == DW'(KEY));

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= fire;
  end
endmodule

// File: rtl/irq_rst_regbank.sv
module irq_rst_regbank
  import irq_rb_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NEV = EVT_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic [NEV-1:0] evt_i,
  output logic          irq_o,
  output logic          soft_rst_o
);
  localparam int unsigned GATE_BIT = DW - 1;

  reg_sel_e       sel;
  logic           fire;
  logic [NEV-1:0] sts_q, en_q, sts_d, en_d;
  logic           gate_q, gate_d;
  logic           irq_q;
  logic [DW-1:0]  rdata_q, rdata_d;

  irq_rb_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  irq_rb_softrst #(.DW(DW), .KEY(RST_KEY)) u_srst (
    .clk     (clk),
    .rst     (rst),
    .hit     (bus_wr && (sel == SEL_RST)),
    .wdata   (bus_wdata),
    .fire    (fire),
    .pulse_q (soft_rst_o)
  );

  irq_rb_status #(.N(NEV)) u_sts (
    .clk    (clk),
    .rst    (rst),
    .clr    (fire),
    .sts_wr (bus_wr && (sel == SEL_STS)),
    .en_wr  (bus_wr && (sel == SEL_EN)),
    .wbits  (bus_wdata[NEV-1:0]),
    .evt    (evt_i),
    .sts_q  (sts_q),
    .en_q   (en_q),
    .sts_d  (sts_d),
    .en_d   (en_d)
  );

  always_comb begin
    if (fire)                          gate_d = 1'b0;
    else if (bus_wr && sel == SEL_GATE) gate_d = bus_wdata[GATE_BIT];
    else                               gate_d = gate_q;
  end

  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      case (sel)
        SEL_GATE: rdata_d[GATE_BIT]  = gate_q;
        SEL_STS:  rdata_d[NEV-1:0]   = sts_q;
        SEL_EN:   rdata_d[NEV-1:0]   = en_q;
        default:  rdata_d            = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      gate_q  <= gate_d;
      irq_q   <= gate_d & (|(sts_d & en_d));
      rdata_q <= rdata_d;
    end
  end

  assign irq_o     = irq_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/irq_rst_regbank_chk.sv
module irq_rst_regbank_chk
  import irq_rb_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NEV = EVT_N
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_wr,
  input logic [DW-1:0]  bus_wdata,
  input logic           bus_rd,
  input logic [DW-1:0]  bus_rdata,
  input logic [NEV-1:0] evt_i,
  input logic           irq_o,
  input logic           soft_rst_o,
  input logic [NEV-1:0] sts,
  input logic [NEV-1:0] en,
  input logic           gate
);
  logic key_wr, mapped;
  assign key_wr = bus_wr && bus_addr == AW'(OFS_RST) && bus_wdata == DW'(RST_KEY);
  assign mapped = bus_addr == AW'(OFS_GATE) || bus_addr == AW'(OFS_STS) ||
                  bus_addr == AW'(OFS_EN);

  // R2
  sts_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(OFS_STS) && bus_wdata[NEV-1:0] == '0 && evt_i == '0)
      |=> $stable(sts));

  // R3
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((|evt_i) && !key_wr) |=> ((sts & $past(evt_i)) == $past(evt_i)));

  // R4
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (gate && (|(sts & en))));

  // R5
  gate_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !gate |-> !irq_o);

  // R6
  srst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> $past(key_wr));

  // R6
  srst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> (sts == '0 && en == '0 && !gate));

  // R7
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(OFS_RST) && bus_wdata != DW'(RST_KEY)) |=> !soft_rst_o);

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || !mapped) |=> bus_rdata == '0);
endmodule

bind irq_rst_regbank irq_rst_regbank_chk #(.AW(AW), .DW(DW), .NEV(NEV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .evt_i      (evt_i),
  .irq_o      (irq_o),
  .soft_rst_o (soft_rst_o),
  .sts        (sts_q),
  .en         (en_q),
  .gate       (gate_q)
);

// File: tb/test_irq_rst_regbank.sv
module test_irq_rst_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_i = '0;
  logic        irq_o, soft_rst_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_sts = '0, m_en = '0;
  logic       m_gate = 1'b0;

  always #4 clk = ~clk;

  irq_rst_regbank i_irq_rst_regbank (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
    .evt_i (evt_i), .irq_o (irq_o), .soft_rst_o (soft_rst_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h1C:   return {m_gate, 31'b0};
      8'h20:   return {24'b0, m_sts};
      8'h28:   return {24'b0, m_en};
      default: return 32'b0;
    endcase
  endfunction

  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic rd, input logic [7:0] ev, input string tag);
    logic [31:0] exp_rd;
    logic        key;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_rd = rd; evt_i = ev;
    @(posedge clk);
    exp_rd = rd ? model_read(a) : 32'b0;
    key = wr && a == 8'h40 && d == 32'hA;
    if (key) begin
      m_sts = '0; m_en = '0; m_gate = 1'b0;
    end else begin
      if (wr && a == 8'h20) m_sts = m_sts ^ d[7:0];
      m_sts = m_sts | ev;
      if (wr && a == 8'h28) m_en = d[7:0];
      if (wr && a == 8'h1C) m_gate = d[31];
    end
    #2;
    chk(tag, "rdata", bus_rdata, exp_rd);
    chk(tag, "irq", {31'b0, irq_o}, {31'b0, m_gate & (|(m_sts & m_en))});
    chk(tag, "soft_rst", {31'b0, soft_rst_o}, {31'b0, key});
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 1'b0, 8'h00, tag);
  endtask

  task automatic rd_reg(input logic [7:0] a, input string tag);
    step(1'b0, a, 32'b0, 1'b1, 8'h00, tag);
  endtask

  task automatic set_sts(input logic [7:0] v, input string tag);
    wr_reg(8'h20, {24'b0, m_sts ^ v}, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    chk("R9", "rdata", bus_rdata, 32'b0);
    chk("R9", "irq", {31'b0, irq_o}, 32'b0);
    chk("R9", "soft_rst", {31'b0, soft_rst_o}, 32'b0);
    @(negedge clk); rst = 1'b0;
    rd_reg(8'h1C, "R9"); rd_reg(8'h20, "R9"); rd_reg(8'h28, "R9");

    // R1 each event lands in its own bit and sticks
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 8'h00, 32'b0, 1'b0, 8'(1 << k), "R1");
      step(1'b0, 8'h00, 32'b0, 1'b0, 8'h00, "R1");
      rd_reg(8'h20, "R1");
      set_sts(8'h00, "R1");
    end

    // R2 all 256 write masks against pattern 0x5A
    for (int v = 0; v < 256; v++) begin
      set_sts(8'h5A, "R2");
      wr_reg(8'h20, 32'(v) | 32'hFFFF_FF00, "R2");
      rd_reg(8'h20, "R2");
    end

    // R3 event collides with write-one to the same bit
    set_sts(8'h00, "R3");
    step(1'b1, 8'h20, 32'h0000_0011, 1'b0, 8'h01, "R3");
    rd_reg(8'h20, "R3");
    step(1'b1, 8'h20, 32'h0000_0001, 1'b0, 8'h01, "R3");
    rd_reg(8'h20, "R3");

    // R4 R5 enable sweep with both gate values and several status patterns
    for (int g = 0; g < 2; g++) begin
      wr_reg(8'h1C, g ? 32'h8000_0000 : 32'h7FFF_FFFF, "R5");
      rd_reg(8'h1C, "R5");
      for (int p = 0; p < 3; p++) begin
        set_sts(p == 0 ? 8'h01 : (p == 1 ? 8'h80 : 8'h24), "R4");
        for (int e = 0; e < 256; e++) begin
          wr_reg(8'h28, 32'(e), "R4");
        end
        rd_reg(8'h28, "R4");
      end
    end
    // R4 irq follows status acknowledge
    wr_reg(8'h28, 32'h0000_00FF, "R4");
    set_sts(8'h00, "R4");
    step(1'b0, 8'h00, 32'b0, 1'b0, 8'h10, "R4");

    // R7 near-miss keys leave everything as is
    wr_reg(8'h28, 32'h0000_003C, "R7");
    set_sts(8'h66, "R7");
    for (int v = 0; v < 16; v++) begin
      if (v != 10) wr_reg(8'h40, 32'(v), "R7");
    end
    wr_reg(8'h40, 32'h8000_000A, "R7");
    wr_reg(8'h40, 32'h0000_001A, "R7");
    rd_reg(8'h28, "R7"); rd_reg(8'h20, "R7"); rd_reg(8'h1C, "R7");

    // R6 valid key with a colliding event
    step(1'b1, 8'h40, 32'h0000_000A, 1'b0, 8'hFF, "R6");
    rd_reg(8'h20, "R6"); rd_reg(8'h28, "R6"); rd_reg(8'h1C, "R6");

    // R8 reads of all word offsets, and no read request
    set_sts(8'hC3, "R8");
    wr_reg(8'h28, 32'h0000_0055, "R8");
    for (int a = 0; a <= 8'h44; a += 4) rd_reg(8'(a), "R8");
    step(1'b0, 8'h20, 32'b0, 1'b0, 8'h00, "R8");

    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; evt_i = '0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule